// File: doc/BRIEF.md
# Store Queue with Load Bypass

This block sits between a cache and a slower next-level memory. Stores from the cache go into a short first-in first-out queue and leave the cache side at once. The queue then empties into memory in the background, one write at a time, through a single request port.

A read miss does not have to wait behind the queued stores. On acceptance the read address is compared with every entry still in the queue in the same cycle. If any entry matches, the block answers the read from the newest matching entry and sends nothing to memory. If no entry matches, the read takes the next free slot on the memory port, ahead of the stores that remain queued. A read can therefore never fetch a value from memory that a pending store is about to replace.

The memory side carries one request register with a valid/ready handshake. Memory must handle requests in the order it accepts them, and it returns read data later with a one-cycle strobe.

Top module: `wbuf_rdprio`

## Requirements
- R1: After reset, `st_full` is 0, `mem_req_valid` is 0, `rd_resp_valid` is 0 and `rd_ready` is 1.
- R2: A store is taken on a clock edge where `st_valid` is 1 and `st_full` is 0. The queue holds `DEPTH` entries (default 4) besides the request register, and `st_full` is 1 while it holds `DEPTH`. A store presented while `st_full` is 1 is dropped and never reaches memory.
- R3: Queued stores reach memory in acceptance order as write requests (`mem_req_write` = 1). A request stays unchanged while `mem_req_valid` is 1 and `mem_req_ready` is 0.
- R4: A read accepted while a queued entry has an equal address returns `rd_resp_valid` = 1 one cycle later, with the data of that entry. No memory read is issued for it.
- R5: A store taken in the same cycle as a read is treated as younger than that read and is not forwarded to it.
- R6: A read that matches no queued entry becomes a memory read request (`mem_req_write` = 0) at `rd_addr`. It is loaded into the request register before any store still waiting in the queue.
- R7: For a memory read, `rd_resp_valid` rises one cycle after `mem_rd_valid` and carries that cycle's `mem_rd_data`.
- R8: `rd_ready` is 0 from the cycle after a read miss is accepted until the cycle its response appears. No response appears in the cycle right after a miss is accepted.
- R9: Every read returns the value of the latest store to its address taken before the read, or the memory's initial content if there is no such store.
- R10: Two stores to one address occupy two entries, and both are written to memory in order. Forwarding picks the newer of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request from the cache |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_full | output | 1 | Queue full; stores are not taken |
| rd_valid | input | 1 | Read-miss request |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | Read request can be taken |
| rd_resp_valid | output | 1 | Read data valid strobe |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory request address |
| mem_req_data | output | DW | Memory write data |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rd_valid | input | 1 | Memory read data strobe |
| mem_rd_data | input | DW | Memory read data |

## Verification
The hardest case to produce is a full queue that holds two entries for one address, with a stalled memory port and a read miss waiting behind the stall. Only that case shows both the newest-entry forwarding and the read overtaking the queue.

A directed phase sets up this case. It holds `mem_req_ready` low and fills the queue through the store port. It then issues a hit and a miss, releases the port, and checks the order of the memory transfers. A seeded random phase follows, with reads and stores confined to eight addresses so that matches are frequent. In that phase a reference memory scores every response.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {REQ_RD = 1'b0, REQ_WR = 1'b1} req_kind_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [AW-1:0]             push_addr,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic [AW-1:0]             head_addr,
  output logic [DW-1:0]             head_data,
  output logic [PW-1:0]             head_ptr,
  output logic [CW-1:0]             count,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr,
  output logic [DEPTH-1:0][DW-1:0]  ent_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign ent_addr[g] = addr_q[g];
    assign ent_data[g] = data_q[g];
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign head_ptr  = rd_ptr_q;
  assign count     = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count_q < CW'(DEPTH))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0)); // R3
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [PW-1:0]            head_ptr,
  input  logic [CW-1:0]            count,
  input  logic [AW-1:0]            rd_addr,
  output logic                     hit,
  output logic [PW-1:0]            sel
);
  logic [PW-1:0] idx;

  // Walk from oldest to newest; a later match overrides, so the newest wins.
  always_comb begin
    hit = 1'b0;
    sel = head_ptr;
    idx = head_ptr;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_ptr + PW'(k);
      if ((CW'(k) < count) && (ent_addr[idx] == rd_addr)) begin
        hit = 1'b1;
        sel = idx;
      end
    end
  end
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
  import wbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_need,
  input  logic [AW-1:0] rd_addr,
  input  logic          wq_nonempty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_req_ready,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  output logic          issue_rd,
  output logic          issue_wr
);
  logic          valid_q;
  req_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          slot_free;

  assign slot_free = !valid_q || mem_req_ready;
  assign issue_rd  = slot_free && rd_need;
  assign issue_wr  = slot_free && !rd_need && wq_nonempty;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      kind_q  <= REQ_RD;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (slot_free) begin
      valid_q <= issue_rd || issue_wr;
      kind_q  <= issue_rd ? REQ_RD : REQ_WR;
      addr_q  <= issue_rd ? rd_addr : head_addr;
      data_q  <= issue_rd ? '0 : head_data;
    end
  end

  assign mem_req_valid = valid_q;
  assign mem_req_write = (kind_q == REQ_WR);
  assign mem_req_addr  = addr_q;
  assign mem_req_data  = data_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data) && $stable(mem_req_write))); // R3
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (rd_need && wq_nonempty && slot_free) |=> (mem_req_valid && !mem_req_write)); // R6
endmodule

// File: rtl/wbuf_rdprio.sv
module wbuf_rdprio #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          st_full,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ready,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req_valid,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_data,
  input  logic          mem_req_ready,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data
);
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [PW-1:0]            head_ptr, sel;
  logic [CW-1:0]            count;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic                     push, hit, rd_fire, issue_rd, issue_wr;
  logic                     rd_need_q, rd_wait_q;
  logic [AW-1:0]            rd_addr_q;

  assign st_full  = (count == CW'(DEPTH));
  assign push     = st_valid && !st_full;
  assign rd_ready = !rd_wait_q;
  assign rd_fire  = rd_valid && rd_ready;

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_addr(st_addr), .push_data(st_data),
    .pop(issue_wr), .head_addr(head_addr), .head_data(head_data),
    .head_ptr(head_ptr), .count(count), .ent_addr(ent_addr), .ent_data(ent_data)
  );

  wbuf_match #(.AW(AW), .DEPTH(DEPTH)) u_match (
    .ent_addr(ent_addr), .head_ptr(head_ptr), .count(count),
    .rd_addr(rd_addr), .hit(hit), .sel(sel)
  );

  wbuf_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .rd_need(rd_need_q), .rd_addr(rd_addr_q),
    .wq_nonempty(count != '0), .head_addr(head_addr), .head_data(head_data),
    .mem_req_ready(mem_req_ready), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .issue_rd(issue_rd), .issue_wr(issue_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_need_q     <= 1'b0;
      rd_wait_q     <= 1'b0;
      rd_addr_q     <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= 1'b0;
      if (rd_fire && hit) begin
        rd_resp_valid <= 1'b1;
        rd_resp_data  <= ent_data[sel];
      end
      if (rd_fire && !hit) begin
        rd_need_q <= 1'b1;
        rd_wait_q <= 1'b1;
        rd_addr_q <= rd_addr;
      end else if (issue_rd) begin
        rd_need_q <= 1'b0;
      end
      if (rd_wait_q && mem_rd_valid) begin
        rd_wait_q     <= 1'b0;
        rd_resp_valid <= 1'b1;
        rd_resp_data  <= mem_rd_data;
      end
    end
  end

  AST_HIT_SKIPS_MEM: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && hit) |=> (rd_resp_valid && !rd_need_q)); // R4
  AST_MISS_NO_EARLY_RESP: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && !hit) |=> (!rd_resp_valid && !rd_ready)); // R8
  AST_FULL_STOPS_PUSH: assert property (@(posedge clk) disable iff (rst)
    (st_full && !issue_wr) |=> st_full); // R2
endmodule

// File: tb/wbuf_rdprio_tb.sv
module wbuf_rdprio_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          st_valid, rd_valid, mem_req_ready;
  logic [AW-1:0] st_addr, rd_addr;
  logic [DW-1:0] st_data;
  logic          st_full, rd_ready, rd_resp_valid;
  logic [DW-1:0] rd_resp_data;
  logic          mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_data;
  logic          mem_rd_valid;
  logic [DW-1:0] mem_rd_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbuf_rdprio #(.AW(AW), .DW(DW), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_full(st_full), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_req_ready(mem_req_ready), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return 32'hA000_0000 + DW'(a);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model, reference memory and response scoreboard
  logic [DW-1:0] mem_m  [16];
  logic [DW-1:0] golden [16];
  logic [DW-1:0] expq [$];
  logic          p0, p1;
  logic [DW-1:0] d0, d1;
  logic          log_en = 1'b0;
  logic [AW:0]   xlog [16];
  int            xcnt = 0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_m[i]  = init_val(i);
      golden[i] = init_val(i);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      p0 <= 1'b0; p1 <= 1'b0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
    end else begin
      p0 <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (log_en && xcnt < 16) begin
          xlog[xcnt] = {mem_req_write, mem_req_addr};
          xcnt++;
        end
        if (mem_req_write) mem_m[mem_req_addr[3:0]] <= mem_req_data;
        else begin p0 <= 1'b1; d0 <= mem_m[mem_req_addr[3:0]]; end
      end
      p1 <= p0; d1 <= d0;
      mem_rd_valid <= p1; mem_rd_data <= d1;
      if (rd_resp_valid) begin
        if (expq.size() == 0) check(1'b0, "R9 unexpected response", 64'(rd_resp_data), 64'h0);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          check(rd_resp_data == e, "R9 read value", 64'(rd_resp_data), 64'(e));
        end
      end
      if (rd_valid && rd_ready) expq.push_back(golden[rd_addr[3:0]]); // R5: before same-cycle store
      if (st_valid && !st_full) golden[st_addr[3:0]] = st_data;
    end
  end

  task automatic do_store(input int a, input logic [DW-1:0] d);
    st_valid = 1'b1; st_addr = AW'(a); st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_read(input int a);
    rd_valid = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic wait_resp(output logic [DW-1:0] d, output bit seen);
    seen = 1'b0; d = '0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (rd_resp_valid) begin seen = 1'b1; d = rd_resp_data; end
      else @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    bit seen;
    logic [AW:0] exp_log [6];
    void'($urandom(32'd20240611));
    rst = 1'b1; st_valid = 0; rd_valid = 0; mem_req_ready = 0;
    st_addr = '0; rd_addr = '0; st_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(st_full == 0 && mem_req_valid == 0 && rd_resp_valid == 0 && rd_ready == 1,
          "R1 reset outputs", {st_full, mem_req_valid, rd_resp_valid, rd_ready}, 4'b0001);

    // Directed: stalled port, full queue with a duplicate address
    log_en = 1'b1;
    do_store(9, 32'h99);
    do_store(3, 32'h11);
    do_store(5, 32'h33);
    do_store(3, 32'h22);
    do_store(6, 32'h44);
    check(st_full == 1, "R2 full after four queued", st_full, 1);
    do_store(1, 32'h55); // dropped while full
    do_read(3);
    check(rd_resp_valid == 1 && rd_resp_data == 32'h22, "R4 R10 newest match forwarded",
          rd_resp_data, 32'h22);
    check(mem_req_valid && mem_req_write && mem_req_addr == 9, "R4 no memory read on hit",
          {mem_req_write, mem_req_addr}, {1'b1, 16'd9});
    do_read(12);
    check(rd_ready == 0, "R8 ready low during miss", rd_ready, 0);
    mem_req_ready = 1'b1;
    wait_resp(d, seen);
    check(seen && d == init_val(12), "R7 memory read data", d, init_val(12));
    repeat (20) @(negedge clk);
    log_en = 1'b0;
    exp_log[0] = {1'b1, 16'd9};  exp_log[1] = {1'b0, 16'd12};
    exp_log[2] = {1'b1, 16'd3};  exp_log[3] = {1'b1, 16'd5};
    exp_log[4] = {1'b1, 16'd3};  exp_log[5] = {1'b1, 16'd6};
    check(xcnt == 6, "R2 R10 transfer count", xcnt, 6);
    for (int i = 0; i < 6; i++)
      check(xlog[i] == exp_log[i], (i == 1) ? "R6 read overtakes queue" : "R3 drain order",
            xlog[i], exp_log[i]);
    do_read(3);
    wait_resp(d, seen);
    check(seen && d == 32'h22, "R10 memory holds newest", d, 32'h22);
    @(negedge clk);
    do_read(1);
    wait_resp(d, seen);
    check(seen && d == init_val(1), "R2 dropped store ignored", d, init_val(1));
    @(negedge clk);

    // R5: store and read of one address in the same cycle
    st_valid = 1; st_addr = 2; st_data = 32'h77;
    rd_valid = 1; rd_addr = 2;
    @(negedge clk);
    st_valid = 0; rd_valid = 0;
    wait_resp(d, seen);
    check(seen && d == init_val(2), "R5 same-cycle store not forwarded", d, init_val(2));
    @(negedge clk);
    do_read(2);
    wait_resp(d, seen);
    check(seen && d == 32'h77, "R9 later read sees store", d, 32'h77);
    @(negedge clk);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      st_valid = ($urandom % 3) == 0;
      st_addr  = AW'($urandom % 8);
      st_data  = $urandom;
      rd_valid = ($urandom % 4) == 0;
      rd_addr  = AW'($urandom % 8);
      mem_req_ready = ($urandom % 3) != 0;
      @(negedge clk);
    end
    st_valid = 0; rd_valid = 0; mem_req_ready = 1;
    repeat (60) @(negedge clk);
    check(expq.size() == 0, "R9 all reads answered", expq.size(), 0);
    check(mem_req_valid == 0 && st_full == 0, "R3 queue drained", {mem_req_valid, st_full}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule